// File: doc/BRIEF.md
# Power-of-Two Rate-Monotonic Link Trigger Scheduler

This block paces transmission for a set of logical links on a fixed time grid. An internal divider cuts time into equal slots; each slot stands for one base interval, nominally a millisecond. Each link has a period of 2^k slots, with k from 0 to 7, and an enable bit. The slot counter runs over 128 slots and then wraps, so the whole schedule repeats every 128 slots.

At the start of every slot the block works out which enabled links are due. It then hands them one at a time to a downstream frame generator. Shorter periods go first, and among links with the same period the lower index goes first. After each trigger the block waits for a done pulse from the generator before it issues the next one. Any due links still waiting when the next slot begins are dropped, and a sticky overrun flag is set. The period and enable settings are static inputs, set by the integrator and held constant while the block runs.

Top module: `lnk_rate_sched`

## Requirements
- R1: `slot_o` resets to 127 and advances by one, modulo 128, every SLOT_CYCLES clocks. The first step, to 0, takes effect at the SLOT_CYCLES-th rising edge after reset is released.
- R2: Take an enabled link with exponent k on `cfg_exp_i`. With no overrun, it is triggered in zero-based slot s exactly when s+1 is a multiple of 2^k. Over one 128-slot cycle this gives 128/2^k triggers.
- R3: A link whose bit in `cfg_en_i` is 0 is never triggered.
- R4: Within a slot, triggers are issued in ascending exponent order. Links with equal exponents go in ascending index order. `link_o` carries the index during the trigger cycle.
- R5: `trig_o` is a one-cycle pulse. After a trigger, no further trigger is issued until `done_i` has been sampled high. A `done_i` in the same cycle as `trig_o` counts.
- R6: A slot's first trigger appears in the cycle after `slot_o` changes, provided nothing is outstanding. Each later trigger appears two cycles after the cycle in which `done_i` was high.
- R7: Suppose a tick arrives while some due links of the ending slot have not yet been triggered. Those links are dropped and never triggered. `overrun_o` rises in the next cycle and stays high until reset.
- R8: `done_i` has no effect while no trigger is outstanding.
- R9: A trigger still outstanding when a new slot begins holds back that slot's triggers until its `done_i` arrives.
- R10: While reset is asserted, `trig_o` and `overrun_o` are 0 and `slot_o` is 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | NUM_LINKS | Per-link enable, static |
| cfg_exp_i | input | NUM_LINKS x EXP_W | Per-link period exponent k (period 2^k slots), static |
| done_i | input | 1 | Downstream generator finished the outstanding trigger |
| trig_o | output | 1 | One-cycle transmit trigger |
| link_o | output | clog2(NUM_LINKS) | Index of the triggered link |
| slot_o | output | 2^EXP_W - 1 | Current zero-based slot number |
| overrun_o | output | 1 | Sticky: due links were dropped at a slot boundary |

## Verification
The hardest case to reach from the ports is a slot boundary that lands while a trigger is still outstanding and other due links are still queued. That boundary must both hold back the new slot's triggers and drop the old leftovers. The bench reaches it by slowing the emulated generator to a 12-cycle done latency. At that latency the busier slots cannot drain inside a 40-cycle slot, so both the held-over trigger and the overrun occur naturally. A run with stray done pulses while idle, and a run with a mixed exponent and enable configuration, cover the ignore rule and the tie-break order.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    // serving state of the trigger sequencer
    typedef enum logic {
        SRV_IDLE = 1'b0,
        SRV_WAIT = 1'b1
    } srv_e;

    // width of a slot number for a given exponent width: 2^(2^exp_w - 1) slots
    function automatic int slot_bits(input int exp_w);
        return (1 << exp_w) - 1;
    endfunction

endpackage

// File: rtl/lrs_tick_div.sv
module lrs_tick_div #(
    parameter int CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == CNT_W'(CYCLES - 1));
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lrs_due_mask.sv
module lrs_due_mask #(
    parameter int NUM_LINKS = 8,
    parameter int EXP_W     = 3,
    parameter int SLOT_W    = 7
) (
    input  logic [SLOT_W-1:0]                  slot_i,
    input  logic [NUM_LINKS-1:0]               en_i,
    input  logic [NUM_LINKS-1:0][EXP_W-1:0]    exp_i,
    output logic [NUM_LINKS-1:0]               due_o
);
    // one-based slot ordinal; a link of exponent k is due when its low k bits are zero (R2)
    logic [SLOT_W-1:0] ord;
    assign ord = slot_i + 1'b1;

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
        logic [SLOT_W-1:0] low_mask;
        assign low_mask = ~({SLOT_W{1'b1}} << exp_i[g]);
        assign due_o[g] = en_i[g] && ((ord & low_mask) == '0);   // R3: disabled never due
    end
endmodule

// File: rtl/lrs_prio_pick.sv
module lrs_prio_pick #(
    parameter int NUM_LINKS = 8,
    parameter int EXP_W     = 3,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_LINKS-1:0]            req_i,
    input  logic [NUM_LINKS-1:0][EXP_W-1:0] exp_i,
    output logic                            valid_o,
    output logic [IDX_W-1:0]                idx_o
);
    logic [EXP_W-1:0] best;

    // R4: smallest exponent wins, strict compare keeps the lowest index on ties
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        best    = '1;
        for (int i = 0; i < NUM_LINKS; i++) begin
            if (req_i[i] && (!valid_o || exp_i[i] < best)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                best    = exp_i[i];
            end
        end
    end
endmodule

// File: rtl/lnk_rate_sched.sv
module lnk_rate_sched #(
    parameter int NUM_LINKS   = 8,
    parameter int EXP_W       = 3,
    parameter int SLOT_CYCLES = 100000
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_LINKS-1:0]                cfg_en_i,
    input  logic [NUM_LINKS-1:0][EXP_W-1:0]     cfg_exp_i,
    input  logic                                done_i,
    output logic                                trig_o,
    output logic [$clog2(NUM_LINKS)-1:0]        link_o,
    output logic [(1<<EXP_W)-2:0]               slot_o,
    output logic                                overrun_o
);
    import lrs_pkg::*;

    localparam int IDX_W  = $clog2(NUM_LINKS);
    localparam int SLOT_W = slot_bits(EXP_W);

    typedef struct packed {
        logic [SLOT_W-1:0]    slot;
        logic [NUM_LINKS-1:0] pend;
        srv_e                 srv;
        logic                 trig;
        logic [IDX_W-1:0]     link;
        logic                 ovf;
    } st_t;

    st_t st_d, st_q;

    logic                 tick;
    logic [SLOT_W-1:0]    slot_inc;
    logic [NUM_LINKS-1:0] due_next;
    logic                 pick_valid;
    logic [IDX_W-1:0]     pick_idx;

    assign slot_inc = st_q.slot + 1'b1;

    lrs_tick_div #(.CYCLES(SLOT_CYCLES)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    lrs_due_mask #(.NUM_LINKS(NUM_LINKS), .EXP_W(EXP_W), .SLOT_W(SLOT_W)) u_due (
        .slot_i (slot_inc),
        .en_i   (cfg_en_i),
        .exp_i  (cfg_exp_i),
        .due_o  (due_next)
    );

    lrs_prio_pick #(.NUM_LINKS(NUM_LINKS), .EXP_W(EXP_W), .IDX_W(IDX_W)) u_pick (
        .req_i   (st_q.pend),
        .exp_i   (cfg_exp_i),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trig = 1'b0;
        // R5/R8: done only matters while a trigger is outstanding
        if (st_q.srv == SRV_WAIT && done_i) st_d.srv = SRV_IDLE;
        if (tick) begin
            // R7: leftovers dropped, flag is sticky; R1: slot step
            if (|st_q.pend) st_d.ovf = 1'b1;
            st_d.slot = slot_inc;
            st_d.pend = due_next;
        end else if (st_q.srv == SRV_IDLE && pick_valid) begin
            // R9: never issues while the previous trigger is open
            st_d.trig           = 1'b1;
            st_d.link           = pick_idx;
            st_d.pend[pick_idx] = 1'b0;
            st_d.srv            = SRV_WAIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.slot <= '1;   // R10: first tick lands on slot 0
            st_q.srv  <= SRV_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o    = st_q.trig;
    assign link_o    = st_q.link;
    assign slot_o    = st_q.slot;
    assign overrun_o = st_q.ovf;
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
    parameter int NUM_LINKS = 8,
    parameter int EXP_W     = 3
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [NUM_LINKS-1:0]                cfg_en_i,
    input logic [NUM_LINKS-1:0][EXP_W-1:0]     cfg_exp_i,
    input logic                                done_i,
    input logic                                trig_o,
    input logic [$clog2(NUM_LINKS)-1:0]        link_o,
    input logic [(1<<EXP_W)-2:0]               slot_o,
    input logic                                overrun_o
);
    localparam int SLOT_W = (1 << EXP_W) - 1;

    logic out_q;
    logic [SLOT_W-1:0] ord;
    logic [SLOT_W-1:0] low_mask;

    assign ord      = slot_o + 1'b1;
    assign low_mask = ~({SLOT_W{1'b1}} << cfg_exp_i[link_o]);

    // watcher's own view of an open trigger
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      out_q <= 1'b0;
        else if (trig_o) out_q <= !done_i;
        else if (done_i) out_q <= 1'b0;
    end

    p_one_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> !out_q);

    p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    p_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> cfg_en_i[link_o]);

    p_on_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> ((ord & low_mask) == '0));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o != $past(slot_o)) |-> (slot_o == SLOT_W'($past(slot_o) + 1)));
endmodule

bind lnk_rate_sched lrs_checker #(.NUM_LINKS(NUM_LINKS), .EXP_W(EXP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en_i  (cfg_en_i),
    .cfg_exp_i (cfg_exp_i),
    .done_i    (done_i),
    .trig_o    (trig_o),
    .link_o    (link_o),
    .slot_o    (slot_o),
    .overrun_o (overrun_o)
);

// File: tb/tb_lnk_rate_sched.sv
module tb_lnk_rate_sched;
    localparam int CLK_PERIOD = 10;
    localparam int SC         = 40;
    localparam int NL         = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NL-1:0]       cfg_en;
    logic [NL-1:0][2:0]  cfg_exp;
    logic                done = 1'b0;
    logic                trig_o;
    logic [2:0]          link_o;
    logic [6:0]          slot_o;
    logic                overrun_o;

    lnk_rate_sched #(.NUM_LINKS(NL), .EXP_W(3), .SLOT_CYCLES(SC)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en_i(cfg_en), .cfg_exp_i(cfg_exp),
        .done_i(done), .trig_o(trig_o), .link_o(link_o), .slot_o(slot_o),
        .overrun_o(overrun_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_cnt, m_slot, m_link, r9_hits;
    int m_q[$];
    bit m_busy, m_trig, m_ovf, m_tick, m_was_busy;

    task automatic build_due(input int s);
        m_q.delete();
        for (int e = 0; e < 8; e++)
            for (int i = 0; i < NL; i++)
                if (cfg_en[i] && int'(cfg_exp[i]) == e && ((s + 1) % (1 << e)) == 0)
                    m_q.push_back(i);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_slot = 127; m_q.delete();
            m_busy = 0; m_trig = 0; m_ovf = 0; m_link = 0;
        end else begin
            m_tick     = (m_cnt == SC - 1);
            m_was_busy = m_busy;
            m_cnt      = m_tick ? 0 : m_cnt + 1;
            m_trig     = 0;
            if (m_was_busy && done) m_busy = 0;
            if (m_tick) begin
                if (m_busy) r9_hits++;
                if (m_q.size() > 0) m_ovf = 1;
                m_slot = (m_slot + 1) % 128;
                build_due(m_slot);
            end else if (!m_was_busy && m_q.size() > 0) begin
                m_link = m_q.pop_front();
                m_trig = 1;
                m_busy = 1;
            end
        end
    end

    // ---------------- compare and emulated generator ----------------
    bit running = 0, gap_en = 0, stray_en = 0, outs = 0;
    int lat = 0, wcnt = 0, cyc = 0;
    int cnt[NL];
    int last_trig_cyc = -1, last_trig_slot = -1, slot_chg_cyc = 0, prev_slot = 127;

    always @(negedge clk) begin
        cyc++;
        if (running) begin
            chk(trig_o === m_trig, "R5 trigger strobe", int'(trig_o), int'(m_trig));
            if (m_trig) chk(int'(link_o) == m_link, "R4 link order", int'(link_o), m_link);
            chk(int'(slot_o) == m_slot, "R1 slot number", int'(slot_o), m_slot);
            chk(overrun_o === m_ovf, "R7 overrun flag", int'(overrun_o), int'(m_ovf));
            if (int'(slot_o) != prev_slot) slot_chg_cyc = cyc;
            prev_slot = int'(slot_o);
            if (trig_o) begin
                chk(!outs, "R9 trigger while open", 1, 0);
                cnt[link_o]++;
                if (gap_en) begin
                    if (int'(slot_o) == last_trig_slot)
                        chk(cyc - last_trig_cyc == 2, "R6 done-to-trigger gap", cyc - last_trig_cyc, 2);
                    else
                        chk(cyc - slot_chg_cyc == 1, "R6 first trigger of slot", cyc - slot_chg_cyc, 1);
                end
                last_trig_cyc  = cyc;
                last_trig_slot = int'(slot_o);
                outs = 1;
                wcnt = lat;
            end
            if (outs) begin
                if (wcnt == 0) begin done = 1; outs = 0; end
                else begin done = 0; wcnt--; end
            end else begin
                done = stray_en && (cyc % 3 == 0);
            end
        end else begin
            done = 0;
            outs = 0;
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%0d expected=0", wd);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic restart();
        @(negedge clk); #1;
        running = 0; rst_n = 0;
        for (int i = 0; i < NL; i++) cnt[i] = 0;
        last_trig_slot = -1; prev_slot = 127; r9_hits = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(trig_o === 1'b0,    "R10 reset trigger", int'(trig_o), 0);
        chk(overrun_o === 1'b0, "R10 reset overrun", int'(overrun_o), 0);
        chk(int'(slot_o) == 127, "R10 reset slot", int'(slot_o), 127);
        rst_n = 1; running = 1;
    endtask

    task automatic cfg_default();
        cfg_en = '1;
        for (int i = 0; i < NL; i++) cfg_exp[i] = 3'(i);
    endtask

    initial begin
        cfg_default();
        // A: full 128-slot cycle, instant generator
        lat = 0; gap_en = 1; stray_en = 0;
        restart();
        repeat (129 * SC - 5) @(negedge clk);
        for (int i = 0; i < NL; i++)
            chk(cnt[i] == (128 >> i), "R2 triggers per cycle", cnt[i], 128 >> i);
        chk(overrun_o === 1'b0, "R7 no overrun when drained", int'(overrun_o), 0);

        // B: mixed exponents, disabled links, slower generator
        gap_en = 0; lat = 3;
        cfg_en = 8'b1010_1101;
        cfg_exp[0] = 3; cfg_exp[1] = 0; cfg_exp[2] = 1; cfg_exp[3] = 1;
        cfg_exp[4] = 0; cfg_exp[5] = 0; cfg_exp[6] = 2; cfg_exp[7] = 2;
        restart();
        repeat (17 * SC - 5) @(negedge clk);
        chk(cnt[1] == 0, "R3 disabled link 1", cnt[1], 0);
        chk(cnt[4] == 0, "R3 disabled link 4", cnt[4], 0);
        chk(cnt[6] == 0, "R3 disabled link 6", cnt[6], 0);
        chk(cnt[5] == 16, "R2 link 5 exponent 0", cnt[5], 16);
        chk(cnt[0] == 2,  "R2 link 0 exponent 3", cnt[0], 2);

        // C: generator too slow, slots overflow
        cfg_default(); lat = 12;
        restart();
        repeat (10 * SC) @(negedge clk);
        chk(overrun_o === 1'b1, "R7 overrun raised", int'(overrun_o), 1);
        chk(r9_hits > 0, "R9 slot began with trigger open", r9_hits, 1);
        lat = 0;
        repeat (3 * SC) @(negedge clk);
        chk(overrun_o === 1'b1, "R7 overrun sticky", int'(overrun_o), 1);

        // D: stray done pulses while idle
        lat = 0; stray_en = 1;
        restart();
        repeat (9 * SC - 5) @(negedge clk);
        chk(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 15, "R8 stray done ignored",
            cnt[0] + cnt[1] + cnt[2] + cnt[3], 15);
        stray_en = 0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule